// File: doc/BRIEF.md
# FWFT Occupancy Flag Generator

This block tracks how many words a first-word-fall-through FIFO holds and turns that count into five status flags: a write-blocked flag, an active-low almost-full flag, an active-low half-full flag, an active-low almost-empty flag and a read-blocked flag. The word presented on the FIFO's output register counts as stored, so a FIFO built on a `DEPTH`-word array holds `DEPTH + 1` words when full. Every threshold therefore sits one word later than it would on a plain FIFO.

The block has one clock, a write request and a read request. The almost-empty offset `n` and the almost-full offset `m` come in as live inputs. Each cycle the block decides which requests are accepted and computes the next count. It then classifies that count into one of six occupancy zones: `ZN_EMPTY`, `ZN_SPARSE`, `ZN_LOWER`, `ZN_UPPER`, `ZN_NEAR_FULL` and `ZN_FULL`.

The zone register is the state machine, and every flag is decoded from it. The zone is always the one matching the next count, so there is no transition table between named states. From any zone the register can move straight to any other zone that a count change of one word, or an offset change, can reach. An active-low reset clears the count and enters `ZN_EMPTY`. The memory array, offset programming and clock-domain crossing live outside this block. `DEPTH` is a power of two.

Top module: `fwft_status_flags`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `word_count` is 0 and the flags read `wr_block`=0, `afull_n`=1, `hfull_n`=1, `aempty_n`=0, `rd_block`=1 (zone `ZN_EMPTY`).
- R2: `rd_block` is 1 exactly when the count is 0. With 1 to n+1 words stored (zone `ZN_SPARSE`), `rd_block` is 0 and `aempty_n` stays 0.
- R3: `aempty_n` is 1 exactly when the count is at least n+2 (zones `ZN_LOWER` and above).
- R4: `hfull_n` is 0 exactly when the count is at least DEPTH/2+2 (zones `ZN_UPPER` and above).
- R5: `afull_n` is 0 exactly when the count is at least DEPTH+1−m (zones `ZN_NEAR_FULL` and `ZN_FULL`).
- R6: `wr_block` is 1 exactly at a count of DEPTH+1 (zone `ZN_FULL`). A write request made while it is 1 is ignored, and the count never exceeds DEPTH+1.
- R7: A read request made while `rd_block` is 1 is ignored, and the count stays at 0 unless a write is accepted in the same cycle.
- R8: An accepted write alone adds one word, an accepted read alone removes one, and an accepted read together with an accepted write leaves the count unchanged.
- R9: The flags and `word_count` are registered and change on the same clock edge, so the flags never lag the count.
- R10: A change of `empty_ofs` or `full_ofs` moves the flags on the next clock edge, even when the count does not change. Valid offsets range from 0 to DEPTH/2−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low master reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| empty_ofs | input | $clog2(DEPTH) | Almost-empty offset n |
| full_ofs | input | $clog2(DEPTH) | Almost-full offset m |
| wr_block | output | 1 | High when full; writes are refused |
| afull_n | output | 1 | Low when count ≥ DEPTH+1−m |
| hfull_n | output | 1 | Low when count ≥ DEPTH/2+2 |
| aempty_n | output | 1 | High when count ≥ n+2 |
| rd_block | output | 1 | High when empty; reads are refused |
| word_count | output | $clog2(DEPTH+2) | Stored words, output register included |

## Verification
The hardest situations to reach are the last zone boundaries next to full. These are the step from DEPTH to DEPTH+1 words, writes pressed against a full FIFO, and a read combined with a write at that count, since over a thousand accepted writes must come first. The stimulus fills the FIFO completely three times, each time with a different pair of offsets, including both extremes of the offset range. It then holds write and mixed requests at full, and repeats the same treatment at empty. Offsets are also changed while the count is held still, to show that the flags move without any count change.

// File: rtl/fwft_flag_pkg.sv
package fwft_flag_pkg;

    typedef enum logic [2:0] {
        ZN_EMPTY     = 3'd0,
        ZN_SPARSE    = 3'd1,
        ZN_LOWER     = 3'd2,
        ZN_UPPER     = 3'd3,
        ZN_NEAR_FULL = 3'd4,
        ZN_FULL      = 3'd5
    } zone_e;

endpackage

// File: rtl/fwft_occupancy_ctr.sv
module fwft_occupancy_ctr #(
    parameter int DEPTH = 1024,
    localparam int CNT_W = $clog2(DEPTH + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_d
);

    localparam logic [CNT_W-1:0] CAPACITY = CNT_W'(DEPTH + 1);

    logic wr_take;
    logic rd_take;

    // Acceptance is decided from the present count, which always matches the flags.
    assign wr_take = wr_en && (count_q != CAPACITY);
    assign rd_take = rd_en && (count_q != '0);

    always_comb begin
        count_d = count_q;
        unique case ({wr_take, rd_take})
            2'b10:   count_d = count_q + CNT_W'(1);
            2'b01:   count_d = count_q - CNT_W'(1);
            default: count_d = count_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

endmodule

// File: rtl/fwft_zone_classify.sv
module fwft_zone_classify
    import fwft_flag_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int CNT_W = $clog2(DEPTH + 2),
    localparam int OFS_W = $clog2(DEPTH)
) (
    input  logic [CNT_W-1:0] count,
    input  logic [OFS_W-1:0] empty_ofs,
    input  logic [OFS_W-1:0] full_ofs,
    output zone_e            zone
);

    localparam logic [CNT_W-1:0] HALF_EDGE = CNT_W'(DEPTH / 2 + 1);
    localparam logic [CNT_W-1:0] ARRAY_SZ  = CNT_W'(DEPTH);

    logic [CNT_W-1:0] sparse_top;
    logic [CNT_W-1:0] upper_top;

    assign sparse_top = CNT_W'(empty_ofs) + CNT_W'(1);
    assign upper_top  = ARRAY_SZ - CNT_W'(full_ofs);

    // Zones are tested in ascending order; valid offsets keep them disjoint.
    always_comb begin
        if (count == '0)               zone = ZN_EMPTY;
        else if (count <= sparse_top)  zone = ZN_SPARSE;
        else if (count <= HALF_EDGE)   zone = ZN_LOWER;
        else if (count <= upper_top)   zone = ZN_UPPER;
        else if (count <= ARRAY_SZ)    zone = ZN_NEAR_FULL;
        else                           zone = ZN_FULL;
    end

endmodule

// File: rtl/fwft_status_flags.sv
module fwft_status_flags
    import fwft_flag_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int CNT_W = $clog2(DEPTH + 2),
    localparam int OFS_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [OFS_W-1:0] empty_ofs,
    input  logic [OFS_W-1:0] full_ofs,
    output logic             wr_block,
    output logic             afull_n,
    output logic             hfull_n,
    output logic             aempty_n,
    output logic             rd_block,
    output logic [CNT_W-1:0] word_count
);

    logic [CNT_W-1:0] count_next;
    zone_e            zone_d;
    zone_e            zone_q;

    fwft_occupancy_ctr #(.DEPTH(DEPTH)) ctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .count_q (word_count),
        .count_d (count_next)
    );

    // Classifying the next count keeps the zone register aligned with the count register.
    fwft_zone_classify #(.DEPTH(DEPTH)) cls_i (
        .count     (count_next),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .zone      (zone_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) zone_q <= ZN_EMPTY;
        else        zone_q <= zone_d;
    end

    always_comb begin
        wr_block = 1'b0;
        afull_n  = 1'b1;
        hfull_n  = 1'b1;
        aempty_n = 1'b0;
        rd_block = 1'b0;
        unique case (zone_q)
            ZN_EMPTY: begin
                rd_block = 1'b1;
            end
            ZN_SPARSE: begin
                aempty_n = 1'b0;
            end
            ZN_LOWER: begin
                aempty_n = 1'b1;
            end
            ZN_UPPER: begin
                aempty_n = 1'b1;
                hfull_n  = 1'b0;
            end
            ZN_NEAR_FULL: begin
                aempty_n = 1'b1;
                hfull_n  = 1'b0;
                afull_n  = 1'b0;
            end
            ZN_FULL: begin
                aempty_n = 1'b1;
                hfull_n  = 1'b0;
                afull_n  = 1'b0;
                wr_block = 1'b1;
            end
            default: begin
                rd_block = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/fwft_status_flags_chk.sv
module fwft_status_flags_chk #(
    parameter int DEPTH = 1024,
    localparam int CNT_W = $clog2(DEPTH + 2)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic             wr_block,
    input logic             afull_n,
    input logic             hfull_n,
    input logic             aempty_n,
    input logic             rd_block,
    input logic [CNT_W-1:0] word_count
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        word_count <= CNT_W'(DEPTH + 1)); // R6

    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_block && wr_en && !rd_en) |=> $stable(word_count)); // R6

    AST_EMPTY_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_block && rd_en && !wr_en) |=> $stable(word_count)); // R7

    AST_MIXED_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_block && !rd_block && wr_en && rd_en) |=> $stable(word_count)); // R8

    AST_EMPTY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        rd_block == (word_count == '0)); // R2

    AST_FULL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_block == (word_count == CNT_W'(DEPTH + 1))); // R9

    AST_HALF_ABOVE_AE: assert property (@(posedge clk) disable iff (!rst_n)
        !hfull_n |-> aempty_n); // R3

    AST_AF_ABOVE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        !afull_n |-> !hfull_n); // R5

endmodule

bind fwft_status_flags fwft_status_flags_chk #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .wr_block   (wr_block),
    .afull_n    (afull_n),
    .hfull_n    (hfull_n),
    .aempty_n   (aempty_n),
    .rd_block   (rd_block),
    .word_count (word_count)
);

// File: tb/fwft_status_flags_tb.sv
`timescale 1ns/1ps
module fwft_status_flags_tb_top;

    localparam int DEPTH = 1024;
    localparam int CNT_W = $clog2(DEPTH + 2);
    localparam int OFS_W = $clog2(DEPTH);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [OFS_W-1:0] empty_ofs = '0;
    logic [OFS_W-1:0] full_ofs = '0;
    logic             wr_block, afull_n, hfull_n, aempty_n, rd_block;
    logic [CNT_W-1:0] word_count;

    int checks = 0;
    int failures = 0;
    int model_cnt = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fwft_status_flags #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs),
        .wr_block(wr_block), .afull_n(afull_n), .hfull_n(hfull_n),
        .aempty_n(aempty_n), .rd_block(rd_block), .word_count(word_count)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at count=%0d", req, act, exp, model_cnt);
        end
    endtask

    // Compare every port against the behavioural model.
    task automatic compare_all();
        int n = int'(empty_ofs);
        int m = int'(full_ofs);
        check("R8 word_count", int'(word_count), model_cnt);
        check("R2 rd_block",   int'(rd_block),   int'(model_cnt == 0));
        check("R3 aempty_n",   int'(aempty_n),   int'(model_cnt >= n + 2));
        check("R4 hfull_n",    int'(hfull_n),    int'(!(model_cnt >= DEPTH / 2 + 2)));
        check("R5 afull_n",    int'(afull_n),    int'(!(model_cnt >= DEPTH + 1 - m)));
        check("R6 wr_block",   int'(wr_block),   int'(model_cnt == DEPTH + 1));
    endtask

    // One cycle: drive at the falling edge, update the model at the rising edge, compare at the next falling edge.
    task automatic step(input bit w, input bit r);
        bit wt = w && (model_cnt != DEPTH + 1);
        bit rt = r && (model_cnt != 0);
        wr_en = w;
        rd_en = r;
        @(posedge clk);
        if (wt && !rt) model_cnt++;
        else if (rt && !wt) model_cnt--;
        @(negedge clk);
        compare_all();
    endtask

    task automatic fill_and_drain(input int n, input int m);
        empty_ofs = OFS_W'(n);
        full_ofs  = OFS_W'(m);
        step(1'b0, 1'b0);
        while (model_cnt < DEPTH + 1) step(1'b1, 1'b0);
        // R6: writes against a full FIFO are ignored
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        check("R6 held at full", int'(word_count), DEPTH + 1);
        // mixed request at full: only the read is taken
        step(1'b1, 1'b1);
        check("R8 mixed at full", int'(word_count), DEPTH);
        step(1'b1, 1'b1);
        check("R8 mixed steady", int'(word_count), DEPTH);
        while (model_cnt > 0) step(1'b0, 1'b1);
        // R7: reads against an empty FIFO are ignored
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
        check("R7 held at empty", int'(word_count), 0);
        step(1'b1, 1'b1);
        check("R7 mixed at empty", int'(word_count), 1);
        step(1'b0, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        check("R1 count in reset", int'(word_count), 0);
        check("R1 rd_block in reset", int'(rd_block), 1);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 count", int'(word_count), 0);
        check("R1 flags", int'({wr_block, afull_n, hfull_n, aempty_n, rd_block}), 5'b01101);

        fill_and_drain(3, 5);
        fill_and_drain(0, 0);
        fill_and_drain(DEPTH / 2 - 1, DEPTH / 2 - 1);

        // R10: offset change moves flags with the count held still
        empty_ofs = OFS_W'(2);
        full_ofs  = OFS_W'(2);
        repeat (5) step(1'b1, 1'b0);
        check("R10 aempty_n before", int'(aempty_n), 1);
        empty_ofs = OFS_W'(4);
        step(1'b0, 1'b0);
        check("R10 aempty_n after", int'(aempty_n), 0);
        check("R10 count kept", int'(word_count), 5);

        // R9: flags move on the edge where the count first reaches the threshold
        while (model_cnt < DEPTH / 2 + 1) step(1'b1, 1'b0);
        check("R9 hfull_n before", int'(hfull_n), 1);
        step(1'b1, 1'b0);
        check("R9 hfull_n same edge", int'(hfull_n), 0);

        // R1: reset in mid-run returns to the empty pattern
        @(negedge clk);
        rst_n = 1'b0;
        model_cnt = 0;
        @(negedge clk);
        check("R1 mid reset count", int'(word_count), 0);
        check("R1 mid reset flags", int'({wr_block, afull_n, hfull_n, aempty_n, rd_block}), 5'b01101);
        rst_n = 1'b1;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule